// File: doc/BRIEF.md
# Windowed Table Gather Unit

This block turns a stream of indices into a stream of result beats, one beat per index. Each lookup goes to a small local buffer that holds one power-of-two window of a larger table. A separate loader writes the window contents into the buffer and records where the window starts. An index hits only when its upper bits select the loaded window and the buffer is valid. On a hit, the low bits of the index select the buffer element. On a miss, a per-index policy decides what happens: either a 32-bit fill value is written, or the write is suppressed and the destination keeps what it had.

Each index carries a sideband with four items: a type code that sets the index width, the miss policy, the fill value, and a release request. When the release request arrives with the final index of an operation, the buffer becomes invalid once that index has been looked up. Every later index then misses until the loader sets a window again. Each result beat carries a write strobe, so a consumer can tell a real write from a skipped one.

Top module: `win_gather`

## Requirements
- R1: The index type code picks how many low bits of `idx_data` form the unsigned index: 8'h03 uses bits [7:0], 8'h05 uses bits [15:0] and 8'h09 uses all 32 bits. Higher bits are ignored for the narrow codes.
- R2: Any other type code is rejected. The beat has `res_bad_type`=1 and `res_wr_en`=0, and `res_data` keeps its previous value.
- R3: An index hits when the buffer is valid and `index & ~(BUF_DEPTH-1)` equals the window start. The start is stored as `win_base & ~(BUF_DEPTH-1)`. A hit writes buffer element `index & (BUF_DEPTH-1)` unchanged, with `res_wr_en`=1.
- R4: A miss with `idx_miss_fill`=1 writes `idx_fill` with `res_wr_en`=1.
- R5: A miss with `idx_miss_fill`=0 gives `res_wr_en`=0. `res_data` changes only on beats that write.
- R6: `idx_ready` is high whenever reset is not active. Every accepted index gives exactly one beat with `res_valid`=1 in the cycle after acceptance. No beat appears without an accepted index.
- R7: An accepted index with both `idx_last`=1 and `idx_release`=1 is still looked up against the valid buffer. After it, every index misses until `win_set` is pulsed. A release request without `idx_last` has no effect.
- R8: Before the first `win_set` after reset, every index misses.
- R9: During reset `idx_ready` and `res_valid` are 0. After reset `res_data` is 0 and `res_wr_en` is 0.
- R10: `res_last` on a beat equals the `idx_last` of the index that produced it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| buf_wr_en | input | 1 | Loader write strobe for one buffer element |
| buf_wr_addr | input | $clog2(BUF_DEPTH) | Buffer element address |
| buf_wr_data | input | DATA_W | Buffer element value |
| win_set | input | 1 | Records the window start and marks the buffer valid |
| win_base | input | IDX_W | Window start index (aligned down to the window size) |
| idx_valid | input | 1 | Index beat offered |
| idx_ready | output | 1 | Index beat accepted when high with idx_valid |
| idx_data | input | IDX_W | Raw index bits |
| idx_type | input | 8 | Index width code |
| idx_miss_fill | input | 1 | 1: write fill on miss, 0: skip write on miss |
| idx_fill | input | DATA_W | Fill value for misses |
| idx_last | input | 1 | Final index of the operation |
| idx_release | input | 1 | Invalidate the buffer after the final index |
| res_valid | output | 1 | Result beat present |
| res_wr_en | output | 1 | Beat carries a real write |
| res_bad_type | output | 1 | Beat came from a rejected type code |
| res_last | output | 1 | Beat belongs to the final index |
| res_data | output | DATA_W | Written value (held when no write) |

## Verification
A wrong hit test or a stale valid flag shows up on the very next beat. `res_data` would carry a buffer element where the fill value belongs, or `res_wr_en` would be set where a skip belongs. A wrong width decode makes the upper-bit noise in `idx_data` reach the window compare, so narrow indices that should hit miss instead. A release that takes effect too early corrupts the final index itself. One that is lost lets the index after it hit, so both cases appear within one beat of the release.

// File: rtl/win_gather_pkg.sv
package win_gather_pkg;

    localparam logic [7:0] IDX_CODE_U8  = 8'h03;
    localparam logic [7:0] IDX_CODE_U16 = 8'h05;
    localparam logic [7:0] IDX_CODE_U32 = 8'h09;

    typedef enum logic [1:0] {
        RES_HIT    = 2'd0,
        RES_FILL   = 2'd1,
        RES_SKIP   = 2'd2,
        RES_REJECT = 2'd3
    } res_kind_e;

endpackage

// File: rtl/win_gather_idx_decode.sv
module win_gather_idx_decode
    import win_gather_pkg::*;
#(
    parameter int IDX_W = 32
) (
    input  logic [7:0]       type_code,
    input  logic [IDX_W-1:0] raw,
    output logic [IDX_W-1:0] index,
    output logic             legal
);

    always_comb begin
        index = '0;
        legal = 1'b1;
        case (type_code)
            IDX_CODE_U8:  index = IDX_W'(raw[7:0]);
            IDX_CODE_U16: index = IDX_W'(raw[15:0]);
            IDX_CODE_U32: index = raw;
            default:      legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/win_gather_table.sv
module win_gather_table #(
    parameter int DEPTH  = 512,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     set_i,
    input  logic [IDX_W-1:0]         base_i,
    input  logic                     release_i,
    input  logic [IDX_W-1:0]         rd_index,
    output logic                     hit,
    output logic [DATA_W-1:0]        rd_data
);

    localparam int               AW   = $clog2(DEPTH);
    localparam logic [IDX_W-1:0] MASK = IDX_W'(DEPTH - 1);

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] base;
    } win_t;

    win_t win_d, win_q;
    logic [DATA_W-1:0] mem [DEPTH];

    always_comb begin
        win_d = win_q;
        if (release_i) win_d.valid = 1'b0;
        if (set_i) begin
            win_d.valid = 1'b1;
            win_d.base  = base_i & ~MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign hit     = win_q.valid && ((rd_index & ~MASK) == win_q.base);
    assign rd_data = mem[rd_index[AW-1:0]];

endmodule

// File: rtl/win_gather.sv
module win_gather
    import win_gather_pkg::*;
#(
    parameter int BUF_DEPTH = 512,
    parameter int DATA_W    = 32,
    parameter int IDX_W     = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         buf_wr_en,
    input  logic [$clog2(BUF_DEPTH)-1:0] buf_wr_addr,
    input  logic [DATA_W-1:0]            buf_wr_data,
    input  logic                         win_set,
    input  logic [IDX_W-1:0]             win_base,
    input  logic                         idx_valid,
    output logic                         idx_ready,
    input  logic [IDX_W-1:0]             idx_data,
    input  logic [7:0]                   idx_type,
    input  logic                         idx_miss_fill,
    input  logic [DATA_W-1:0]            idx_fill,
    input  logic                         idx_last,
    input  logic                         idx_release,
    output logic                         res_valid,
    output logic                         res_wr_en,
    output logic                         res_bad_type,
    output logic                         res_last,
    output logic [DATA_W-1:0]            res_data
);

    typedef struct packed {
        logic              ready;
        logic              vld;
        logic              we;
        logic              bad;
        logic              last;
        logic [DATA_W-1:0] data;
    } st_t;

    st_t st_d, st_q;

    logic [IDX_W-1:0]  index;
    logic              legal;
    logic              hit;
    logic [DATA_W-1:0] buf_data;
    logic              accept;
    logic              drop_win;
    res_kind_e         kind;

    assign accept   = idx_valid && st_q.ready;
    assign drop_win = accept && idx_last && idx_release;

    win_gather_idx_decode #(.IDX_W(IDX_W)) u_dec (
        .type_code (idx_type),
        .raw       (idx_data),
        .index     (index),
        .legal     (legal)
    );

    win_gather_table #(.DEPTH(BUF_DEPTH), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_tbl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (buf_wr_en),
        .wr_addr   (buf_wr_addr),
        .wr_data   (buf_wr_data),
        .set_i     (win_set),
        .base_i    (win_base),
        .release_i (drop_win),
        .rd_index  (index),
        .hit       (hit),
        .rd_data   (buf_data)
    );

    always_comb begin
        if (!legal)             kind = RES_REJECT;
        else if (hit)           kind = RES_HIT;
        else if (idx_miss_fill) kind = RES_FILL;
        else                    kind = RES_SKIP;
    end

    always_comb begin
        st_d       = st_q;
        st_d.ready = 1'b1;
        st_d.vld   = accept;
        st_d.we    = 1'b0;
        st_d.bad   = 1'b0;
        if (accept) begin
            st_d.last = idx_last;
            case (kind)
                RES_HIT: begin
                    st_d.we   = 1'b1;
                    st_d.data = buf_data;
                end
                RES_FILL: begin
                    st_d.we   = 1'b1;
                    st_d.data = idx_fill;
                end
                RES_REJECT: st_d.bad = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign idx_ready    = st_q.ready;
    assign res_valid    = st_q.vld;
    assign res_wr_en    = st_q.we;
    assign res_bad_type = st_q.bad;
    assign res_last     = st_q.last;
    assign res_data     = st_q.data;

endmodule

// File: rtl/win_gather_chk.sv
module win_gather_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              idx_valid,
    input logic              idx_ready,
    input logic              idx_last,
    input logic              res_valid,
    input logic              res_wr_en,
    input logic              res_bad_type,
    input logic              res_last,
    input logic [DATA_W-1:0] res_data
);

    // R6
    beat_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_valid && idx_ready) |=> res_valid);

    // R6
    no_phantom_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(idx_valid && idx_ready) |=> !res_valid);

    // R2
    reject_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_bad_type |-> (res_valid && !res_wr_en));

    // R5
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_wr_en |-> $stable(res_data));

    // R10
    last_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_valid && idx_ready) |=> (res_last == $past(idx_last)));

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!res_valid && !idx_ready));

endmodule

bind win_gather win_gather_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .idx_valid    (idx_valid),
    .idx_ready    (idx_ready),
    .idx_last     (idx_last),
    .res_valid    (res_valid),
    .res_wr_en    (res_wr_en),
    .res_bad_type (res_bad_type),
    .res_last     (res_last),
    .res_data     (res_data)
);

// File: tb/win_gather_tb.sv
module win_gather_tb;

    localparam int DEPTH  = 512;
    localparam int AW     = $clog2(DEPTH);
    localparam int NVEC   = 10;
    localparam logic [31:0] FILL = 32'hDEAD_BEEF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          buf_wr_en = 1'b0;
    logic [AW-1:0] buf_wr_addr = '0;
    logic [31:0]   buf_wr_data = '0;
    logic          win_set = 1'b0;
    logic [31:0]   win_base = '0;
    logic          idx_valid = 1'b0;
    logic          idx_ready;
    logic [31:0]   idx_data = '0;
    logic [7:0]    idx_type = 8'h09;
    logic          idx_miss_fill = 1'b1;
    logic [31:0]   idx_fill = FILL;
    logic          idx_last = 1'b0;
    logic          idx_release = 1'b0;
    logic          res_valid, res_wr_en, res_bad_type, res_last;
    logic [31:0]   res_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    win_gather #(.BUF_DEPTH(DEPTH), .DATA_W(32), .IDX_W(32)) u_dut (
        .clk (clk), .rst_n (rst_n),
        .buf_wr_en (buf_wr_en), .buf_wr_addr (buf_wr_addr), .buf_wr_data (buf_wr_data),
        .win_set (win_set), .win_base (win_base),
        .idx_valid (idx_valid), .idx_ready (idx_ready), .idx_data (idx_data),
        .idx_type (idx_type), .idx_miss_fill (idx_miss_fill), .idx_fill (idx_fill),
        .idx_last (idx_last), .idx_release (idx_release),
        .res_valid (res_valid), .res_wr_en (res_wr_en), .res_bad_type (res_bad_type),
        .res_last (res_last), .res_data (res_data)
    );

    // {type, index, miss_fill, exp_we, exp_bad, exp_data}; window start 0x400, entry i = A000_0000|i
    localparam logic [74:0] VEC [NVEC] = '{
        {8'h09, 32'h0000_0405, 1'b1, 1'b1, 1'b0, 32'hA000_0005},
        {8'h09, 32'h0000_0600, 1'b1, 1'b1, 1'b0, FILL},
        {8'h05, 32'hFFFF_0410, 1'b1, 1'b1, 1'b0, 32'hA000_0010},
        {8'h03, 32'hFFFF_FF07, 1'b1, 1'b1, 1'b0, FILL},
        {8'h09, 32'h0000_0000, 1'b0, 1'b0, 1'b0, FILL},
        {8'h09, 32'h0000_05FF, 1'b1, 1'b1, 1'b0, 32'hA000_01FF},
        {8'h09, 32'h0000_03FF, 1'b0, 1'b0, 1'b0, 32'hA000_01FF},
        {8'h04, 32'h0000_0405, 1'b1, 1'b0, 1'b1, 32'hA000_01FF},
        {8'h05, 32'h0001_0401, 1'b0, 1'b1, 1'b0, 32'hA000_0001},
        {8'h09, 32'h8000_0405, 1'b1, 1'b1, 1'b0, FILL}
    };

    function automatic string vec_tag(int i);
        case (i)
            0, 5:    return "R3";
            1, 9:    return "R4";
            2, 3, 8: return "R1";
            4, 6:    return "R5";
            default: return "R2";
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(logic [7:0] t, logic [31:0] d, logic pol, logic last, logic rel);
        @(negedge clk);
        idx_valid = 1'b1; idx_type = t; idx_data = d; idx_miss_fill = pol;
        idx_last = last; idx_release = rel;
        @(negedge clk);
        idx_valid = 1'b0; idx_last = 1'b0; idx_release = 1'b0;
    endtask

    task automatic set_window(logic [31:0] b);
        @(negedge clk);
        win_set = 1'b1; win_base = b;
        @(negedge clk);
        win_set = 1'b0;
    endtask

    initial begin
        // R9 reset state
        @(negedge clk); @(negedge clk);
        check("R9 ready in reset", 32'(idx_ready), 32'd0);
        check("R9 valid in reset", 32'(res_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 ready after reset", 32'(idx_ready), 32'd1);
        check("R9 data after reset", res_data, 32'd0);
        check("R9 we after reset", 32'(res_wr_en), 32'd0);

        // R8 no window loaded: index 0 equals reset start but must miss
        send(8'h09, 32'h0, 1'b1, 1'b0, 1'b0);
        check("R8 miss before load valid", 32'(res_valid), 32'd1);
        check("R8 miss before load data", res_data, FILL);

        // R6 idle cycle gives no beat
        @(negedge clk);
        check("R6 no beat when idle", 32'(res_valid), 32'd0);

        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            buf_wr_en = 1'b1; buf_wr_addr = AW'(i); buf_wr_data = 32'hA000_0000 | i;
        end
        @(negedge clk);
        buf_wr_en = 1'b0;
        set_window(32'h0000_0437);   // R3 start aligned down to 0x400

        for (int i = 0; i < NVEC; i++) begin
            send(VEC[i][74:67], VEC[i][66:35], VEC[i][34], 1'b0, 1'b0);
            check({vec_tag(i), " table valid"}, 32'(res_valid), 32'd1);
            check({vec_tag(i), " table we"}, 32'(res_wr_en), 32'(VEC[i][33]));
            check({vec_tag(i), " table bad"}, 32'(res_bad_type), 32'(VEC[i][32]));
            check({vec_tag(i), " table data"}, res_data, VEC[i][31:0]);
        end

        // R7 release without last is ignored
        send(8'h09, 32'h0000_0402, 1'b1, 1'b0, 1'b1);
        check("R7 release w/o last still hits", res_data, 32'hA000_0002);
        send(8'h09, 32'h0000_0403, 1'b1, 1'b0, 1'b0);
        check("R7 window kept", res_data, 32'hA000_0003);

        // R7 R10 final index with release
        send(8'h09, 32'h0000_0405, 1'b1, 1'b1, 1'b1);
        check("R7 final index hits", res_data, 32'hA000_0005);
        check("R10 last tagged", 32'(res_last), 32'd1);
        send(8'h09, 32'h0000_0406, 1'b1, 1'b0, 1'b0);
        check("R7 miss after release", res_data, FILL);
        check("R10 last cleared", 32'(res_last), 32'd0);
        send(8'h09, 32'h0000_0407, 1'b0, 1'b0, 1'b0);
        check("R7 skip after release", 32'(res_wr_en), 32'd0);

        // R1 8-bit hit with upper noise, window at 0
        set_window(32'h0000_0000);
        send(8'h03, 32'h1234_ABCD, 1'b1, 1'b0, 1'b0);
        check("R1 8-bit index hit", res_data, 32'hA000_00CD);
        send(8'h09, 32'h1234_ABCD, 1'b1, 1'b0, 1'b0);
        check("R1 32-bit same bits miss", res_data, FILL);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule